// File: doc/BRIEF.md
# Crosspoint Switch Configuration Register

This block holds the routing setup for a switch matrix with 16 outputs. Each output has a 5-bit entry: a 4-bit code that chooses the input to route and one bit that turns the output on. The 16 entries together form an 80-bit staging chain. Software or a host controller fills the chain in one of two ways. It can stream bits in one per clock, or it can write one addressed 5-bit entry per clock.

A separate bank of output registers drives the matrix. Loading the staging chain has no effect on the live routing. The new setup goes live only when the update control is pulled low with the block enabled. The bank then copies the chain. In serial mode the last chain bit leaves on a serial output, so several blocks can be chained on one data line.

Every state change happens on the falling clock edge. An active-low asynchronous reset turns all outputs off at once. It leaves the staging chain and the input-select codes untouched.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: While `ce_n` is high, no state changes at any falling clock edge, whatever the other inputs do. The staging chain, `ser_out`, `out_sel` and `out_en` all hold.
- R2: Serial load happens when `ce_n`=0, `upd_n`=1 and `load_par`=0. At each falling edge `ser_in` enters chain bit 0 (entry 0, bit 0), and every chain bit moves one place toward bit 79 (entry 15, enable).
- R3: `ser_out` shows chain bit 79. After 80 consecutive serial shifts, it equals the bit that the first of those 80 shifts took in.
- R4: Parallel load happens when `ce_n`=0, `upd_n`=1 and `load_par`=1. At the falling edge `par_data` replaces chain entry `par_addr`, which is bits 5·a to 5·a+4. `par_data[3:0]` is the select code and `par_data[4]` is the enable. The other 15 entries keep their value.
- R5: When `ce_n`=0 and `upd_n`=0, each falling edge copies the whole chain into the output bank, and the chain itself holds.
- R6: The output bank holds its value at every falling edge where `ce_n` or `upd_n` is high, while chain loads go on.
- R7: Asynchronous reset (`rst_n`=0) forces all 16 `out_en` bits to 0 at once and keeps them there. It changes neither `out_sel` nor the staging chain, so a later update restores the enables from the chain.
- R8: Output n takes its select code from chain bits 5n to 5n+3 and shows it on `out_sel[4n+3:4n]`. It takes its enable from chain bit 5n+4 and shows it on `out_en[n]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears output enables only |
| ce_n | input | 1 | Active-low block enable; high freezes all state |
| upd_n | input | 1 | Active-low update; low copies the chain into the output bank |
| load_par | input | 1 | Load mode: 0 serial shift, 1 addressed parallel write |
| ser_in | input | 1 | Serial data into chain bit 0 |
| par_data | input | 5 | Parallel entry: [3:0] select code, [4] enable |
| par_addr | input | 4 | Entry index for a parallel write |
| ser_out | output | 1 | Chain bit 79, for daisy-chaining |
| out_sel | output | 64 | Live select codes, 4 bits per output |
| out_en | output | 16 | Live output enables, one bit per output |

## Verification
The assertions assume that every control input is stable around each falling edge. They also assume that reset is driven a half period away from that edge, so the async clear never races an update capture. The bench drives every input, `rst_n` included, just after the rising edge and reads the outputs at the same point. Its reference model uses the select codes and serial output only after all 16 entries have been written in parallel mode. Until then the power-up chain contents are undefined, so the model does not predict them.

// File: rtl/xpt_cfg_pkg.sv
package xpt_cfg_pkg;

    localparam int XPT_OUTS  = 16;
    localparam int XPT_SEL_W = 4;

    typedef enum logic {
        LOAD_SERIAL   = 1'b0,
        LOAD_PARALLEL = 1'b1
    } load_mode_e;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_SHIFT  = 2'd1,
        OP_WRITE  = 2'd2,
        OP_UPDATE = 2'd3
    } chain_op_e;

    // Enable dominates, then update, then the load mode.
    function automatic chain_op_e pick_op(input logic ce_n, input logic upd_n,
                                          input load_mode_e mode);
        if (ce_n) begin
            return OP_IDLE;
        end
        if (!upd_n) begin
            return OP_UPDATE;
        end
        return (mode == LOAD_PARALLEL) ? OP_WRITE : OP_SHIFT;
    endfunction

endpackage

// File: rtl/xpt_addr_dec.sv
module xpt_addr_dec #(
    parameter int N_OUT  = 16,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    output logic [N_OUT-1:0]  hit
);

    genvar n;
    for (n = 0; n < N_OUT; n++) begin : g_line
        assign hit[n] = en && (addr == ADDR_W'(n));
    end

    // At most one entry may be targeted by a parallel write.
    always_comb begin
        p_dec_single_r4: assert ($countones(hit) ==
                                 ((en && (int'(addr) < N_OUT)) ? 1 : 0));
    end

endmodule

// File: rtl/xpt_cfg_chain.sv
module xpt_cfg_chain
    import xpt_cfg_pkg::*;
#(
    parameter int N_OUT   = 16,
    parameter int ENT_W   = 5,
    localparam int CHAIN_W = N_OUT * ENT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  chain_op_e          op,
    input  logic               ser_in,
    input  logic [N_OUT-1:0]   wr_hit,
    input  logic [ENT_W-1:0]   wr_data,
    output logic [CHAIN_W-1:0] chain_q,
    output logic               ser_out
);

    typedef struct packed {
        logic [CHAIN_W-1:0] bits;
    } chain_t;

    chain_t             st_d;
    chain_t             st_q;
    logic [CHAIN_W-1:0] wr_image_d;

    // Per-entry write multiplexer.
    genvar e;
    for (e = 0; e < N_OUT; e++) begin : g_ent
        assign wr_image_d[e*ENT_W +: ENT_W] =
            wr_hit[e] ? wr_data : st_q.bits[e*ENT_W +: ENT_W];

        p_write_other_keep_r4: assert property (@(negedge clk) disable iff (!rst_n)
            (op == OP_WRITE && !wr_hit[e]) |=> $stable(chain_q[e*ENT_W +: ENT_W]));

        p_write_hit_load_r4: assert property (@(negedge clk) disable iff (!rst_n)
            (op == OP_WRITE && wr_hit[e]) |=> (chain_q[e*ENT_W +: ENT_W] == $past(wr_data)));
    end

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_SHIFT: st_d.bits = {st_q.bits[CHAIN_W-2:0], ser_in};
            OP_WRITE: st_d.bits = wr_image_d;
            default:  st_d      = st_q;
        endcase
    end

    // The chain has no reset: reset only acts on the output enables.
    always_ff @(negedge clk) begin
        st_q <= st_d;
    end

    assign chain_q = st_q.bits;
    assign ser_out = st_q.bits[CHAIN_W-1];

    p_idle_hold_r1: assert property (@(negedge clk) disable iff (!rst_n)
        (op == OP_IDLE) |=> $stable(chain_q));

    p_update_keeps_chain_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (op == OP_UPDATE) |=> $stable(chain_q));

    p_shift_entry_r2: assert property (@(negedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (chain_q[0] == $past(ser_in)) &&
                             (ser_out == $past(chain_q[CHAIN_W-2])));

endmodule

// File: rtl/xpt_out_bank.sv
module xpt_out_bank #(
    parameter int N_OUT   = 16,
    parameter int SEL_W   = 4,
    localparam int ENT_W   = SEL_W + 1,
    localparam int CHAIN_W = N_OUT * ENT_W,
    localparam int SELS_W  = N_OUT * SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               capture,
    input  logic [CHAIN_W-1:0] chain_q,
    output logic [SELS_W-1:0]  out_sel,
    output logic [N_OUT-1:0]   out_en
);

    typedef struct packed {
        logic [SELS_W-1:0] sel;
        logic [N_OUT-1:0]  en;
    } bank_t;

    bank_t             bank_d;
    logic [SELS_W-1:0] sel_q;
    logic [N_OUT-1:0]  en_q;
    logic [SELS_W-1:0] cap_sel;
    logic [N_OUT-1:0]  cap_en;

    // Split each chain entry into its select code and its enable.
    genvar n;
    for (n = 0; n < N_OUT; n++) begin : g_out
        assign cap_sel[n*SEL_W +: SEL_W] = chain_q[n*ENT_W +: SEL_W];
        assign cap_en[n]                 = chain_q[n*ENT_W + SEL_W];
    end

    always_comb begin
        bank_d.sel = sel_q;
        bank_d.en  = en_q;
        if (capture) begin
            bank_d.sel = cap_sel;
            bank_d.en  = cap_en;
        end
    end

    // The select codes are not reset.
    always_ff @(negedge clk) begin
        sel_q <= bank_d.sel;
    end

    // The enables are cleared asynchronously.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= bank_d.en;
        end
    end

    assign out_sel = sel_q;
    assign out_en  = en_q;

    p_capture_r5: assert property (@(negedge clk) disable iff (!rst_n)
        capture |=> (out_sel == $past(cap_sel)) && (out_en == $past(cap_en)));

    p_hold_r6: assert property (@(negedge clk) disable iff (!rst_n)
        !capture |=> $stable(out_sel) && $stable(out_en));

    p_en_clear_after_reset_r7: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_en == '0));

endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
    import xpt_cfg_pkg::*;
#(
    parameter int N_OUT  = XPT_OUTS,
    parameter int SEL_W  = XPT_SEL_W,
    localparam int ENT_W   = SEL_W + 1,
    localparam int ADDR_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    localparam int CHAIN_W = N_OUT * ENT_W,
    localparam int SELS_W  = N_OUT * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              upd_n,
    input  logic              load_par,
    input  logic              ser_in,
    input  logic [ENT_W-1:0]  par_data,
    input  logic [ADDR_W-1:0] par_addr,
    output logic              ser_out,
    output logic [SELS_W-1:0] out_sel,
    output logic [N_OUT-1:0]  out_en
);

    chain_op_e          op;
    logic [N_OUT-1:0]   wr_hit;
    logic [CHAIN_W-1:0] chain_q;

    always_comb begin
        op = pick_op(ce_n, upd_n, load_mode_e'(load_par));
    end

    xpt_addr_dec #(
        .N_OUT  (N_OUT),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr (par_addr),
        .en   (op == OP_WRITE),
        .hit  (wr_hit)
    );

    xpt_cfg_chain #(
        .N_OUT (N_OUT),
        .ENT_W (ENT_W)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .ser_in  (ser_in),
        .wr_hit  (wr_hit),
        .wr_data (par_data),
        .chain_q (chain_q),
        .ser_out (ser_out)
    );

    xpt_out_bank #(
        .N_OUT (N_OUT),
        .SEL_W (SEL_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (op == OP_UPDATE),
        .chain_q (chain_q),
        .out_sel (out_sel),
        .out_en  (out_en)
    );

    p_frozen_outputs_r1: assert property (@(negedge clk) disable iff (!rst_n)
        ce_n |=> $stable(out_sel) && $stable(out_en) && $stable(ser_out));

endmodule

// File: tb/sim_xpt_cfg_ctrl.sv
module sim_xpt_cfg_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NO = 16;
    localparam int SW = 4;
    localparam int EW = 5;
    localparam int CW = NO * EW;

    logic        clk      = 1'b0;
    logic        rst_n    = 1'b1;
    logic        ce_n     = 1'b1;
    logic        upd_n    = 1'b1;
    logic        load_par = 1'b0;
    logic        ser_in   = 1'b0;
    logic [4:0]  par_data = '0;
    logic [3:0]  par_addr = '0;
    logic        ser_out;
    logic [63:0] out_sel;
    logic [15:0] out_en;

    int    n_checks = 0;
    int    n_errs   = 0;
    bit    done     = 0;
    string cur_req  = "R7";

    // Reference model state
    logic [CW-1:0] m_sr  = '0;
    logic [CW-1:0] m_lat = '0;
    bit            wrote [NO];
    bit            sr_known  = 0;
    bit            sel_known = 0;
    bit            en_known  = 0;
    bit            shq [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xpt_cfg_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .upd_n    (upd_n),
        .load_par (load_par),
        .ser_in   (ser_in),
        .par_data (par_data),
        .par_addr (par_addr),
        .ser_out  (ser_out),
        .out_sel  (out_sel),
        .out_en   (out_en)
    );

    // Behavioural reference: one action per falling edge.
    always @(negedge clk) begin
        if (!ce_n) begin
            if (!upd_n) begin
                m_lat = m_sr;
                if (sr_known) begin
                    sel_known = 1;
                    en_known  = 1;
                end
            end else if (!load_par) begin
                m_sr = {m_sr[CW-2:0], ser_in};
                shq.push_back(ser_in);
                if (shq.size() > 80) begin
                    void'(shq.pop_front());
                end
            end else begin
                for (int b = 0; b < EW; b++) begin
                    m_sr[int'(par_addr) * EW + b] = par_data[b];
                end
                wrote[par_addr] = 1;
                shq.delete();
                begin
                    bit all;
                    all = 1;
                    for (int k = 0; k < NO; k++) begin
                        if (!wrote[k]) all = 0;
                    end
                    sr_known = all;
                end
            end
        end
        if (!rst_n) begin
            for (int n = 0; n < NO; n++) begin
                m_lat[n*EW + SW] = 1'b0;
            end
            en_known = 1;
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [63:0] es;
        logic [15:0] ee;
        for (int n = 0; n < NO; n++) begin
            for (int b = 0; b < SW; b++) begin
                es[n*SW + b] = m_lat[n*EW + b];
            end
            ee[n] = m_lat[n*EW + SW];
        end
        if (en_known)  chk("out_en", 64'(out_en), 64'(ee));
        if (sel_known) chk("out_sel", out_sel, es);
        if (sr_known)  chk("ser_out", 64'(ser_out), 64'(m_sr[CW-1]));
        if (shq.size() == 80) chk("ser_out 80-shift latency (R3)", 64'(ser_out), 64'(shq[0]));
    endtask

    task automatic step(input logic c, input logic u, input logic p, input logic s,
                        input logic [4:0] d, input logic [3:0] a);
        @(posedge clk);
        #1;
        compare();
        ce_n     = c;
        upd_n    = u;
        load_par = p;
        ser_in   = s;
        par_data = d;
        par_addr = a;
    endtask

    task automatic rnd_step(input logic c);
        step(c, 1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom), 4'($urandom));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    initial begin
        #1;
        // R7: reset clears enables, chip disabled
        cur_req = "R7";
        rst_n = 1'b0;
        repeat (3) rnd_step(1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 4'd0);
        rst_n = 1'b1;

        // R4: fill every entry by address, overwrite one
        cur_req = "R4";
        for (int e = 0; e < NO; e++) begin
            step(1'b0, 1'b1, 1'b1, 1'b0, 5'($urandom), 4'(e));
        end
        step(1'b0, 1'b1, 1'b1, 1'b0, 5'b10110, 4'd5);
        step(1'b0, 1'b1, 1'b1, 1'b0, 5'b11111, 4'd15);

        // R5: copy chain into bank
        cur_req = "R5";
        step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 4'd0);
        step(1'b0, 1'b0, 1'b1, 1'b1, 5'd3, 4'd7);

        // R6: chain loads continue, bank holds
        cur_req = "R6";
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 1'b1, 1'($urandom), 1'($urandom), 5'($urandom), 4'($urandom));
        end

        // R1: chip disabled, random controls
        cur_req = "R1";
        for (int i = 0; i < 24; i++) rnd_step(1'b1);

        // R2 / R3: long serial stream
        cur_req = "R2";
        for (int i = 0; i < 200; i++) begin
            if (i == 100) cur_req = "R3";
            step(1'b0, 1'b1, 1'b0, 1'($urandom), 5'($urandom), 4'($urandom));
        end
        cur_req = "R5";
        step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 4'd0);

        // R8: distinct pattern per entry, then update
        cur_req = "R8";
        for (int e = 0; e < NO; e++) begin
            step(1'b0, 1'b1, 1'b1, 1'b0, {1'(e % 3 == 0), 4'(15 - e)}, 4'(e));
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 4'd0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 4'd0);

        // R5 / R6: mixed traffic
        cur_req = "R5";
        for (int i = 0; i < 150; i++) begin
            if (i == 75) cur_req = "R6";
            rnd_step(1'($urandom_range(0, 3) == 0));
        end

        // R7: reset mid-operation, including during an update
        cur_req = "R7";
        for (int e = 0; e < NO; e++) begin
            step(1'b0, 1'b1, 1'b1, 1'b0, {1'b1, 4'(e)}, 4'(e));
        end
        step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 4'd0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 4'd0);
        rst_n = 1'b0;
        step(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 4'd0);
        step(1'b0, 1'b1, 1'b1, 1'b0, 5'b00011, 4'd2);
        step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 4'd0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 4'd0);
        rst_n = 1'b1;
        step(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 4'd0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, 4'd0);
        repeat (3) step(1'b1, 1'b1, 1'b0, 1'b0, 5'd0, 4'd0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            summary();
            $finish;
        end
    end

endmodule